// File: doc/BRIEF.md
# Dual Trigger Output Selector

This block turns a timer's internal events and compare-reference levels into two trigger outputs that other blocks (converters, other timers) can use as start signals. A control word holds one mode field per output. The main output picks one of eight sources: the counter reset, the counter-enable level, the update event, the compare-match pulse, or one of compare references 1 to 4 as a level. The auxiliary output understands the same eight codes and eight more. Two of these pass compare references 5 or 6 through as levels. The other six make one-clock pulses from chosen rising and falling edges of compare references 4, 5 and 6.

Edges are found by comparing each reference with its value from the previous clock. Both outputs are registered, so a source sampled at a clock edge appears on the output right after that same edge. A software update strobe forces an update event, and it also counts as a reset event. The auxiliary field can be removed at build time (`HAS_AUX = 0`). In that case writes to it are dropped and it reads back as zero, so software can read the field to find out whether the second output exists.

Top module: `trig_out_select`

## Requirements
- R1: During and after synchronous reset, both mode fields read as zero and both outputs are low.
- R2: A write stores the main mode from bits 6:4 and the auxiliary mode from bits 23:20. A read returns these fields in the same positions, and every other bit reads 0. Writing all ones therefore reads back as 0x00F00070.
- R3: Main mode codes are: 0 = counter reset pulse, 1 = counter-enable level, 2 = update pulse, 3 = compare-match pulse, 4..7 = compare references 1..4 (ocRef bits 0..3) as levels. The output shows the source sampled at a clock edge right after that edge.
- R4: Auxiliary codes 0..7 mean the same as in the main field. Code 8 passes compare reference 5 (ocRef bit 4) and code 9 passes compare reference 6 (ocRef bit 5), both as levels.
- R5: Auxiliary code 10 makes a one-clock pulse on each rising or falling edge of reference 4 (ocRef bit 3), and code 11 does the same for reference 6 (ocRef bit 5). An edge is a change from the value one clock earlier.
- R6: Auxiliary codes 12..15 pulse for one clock on: 12 = rise of ref 4 or rise of ref 6; 13 = rise of ref 4 or fall of ref 6; 14 = rise of ref 5 or rise of ref 6; 15 = rise of ref 5 or fall of ref 6. Edges that are not selected produce no pulse.
- R7: When two selected edges occur in the same clock, exactly one pulse, one clock wide, is produced.
- R8: The software update strobe produces a pulse in update mode (code 2) and in reset mode (code 0). When it falls in the same cycle as a counter reset, the result is a single pulse.
- R9: With `HAS_AUX = 0`, writes to bits 23:20 are ignored, those bits read as zero, and the auxiliary output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Control word write enable |
| regWdata | input | 32 | Control word write data |
| regRdata | output | 32 | Control word read data |
| swUpdate | input | 1 | Software update-generation strobe |
| cntReset | input | 1 | Counter reset strobe |
| cntEnable | input | 1 | Counter enable level |
| cntUpdate | input | 1 | Counter update event strobe |
| cmpMatch | input | 1 | Compare-match strobe |
| ocRef | input | 6 | Compare reference levels 1..6 (bit 0 = ref 1) |
| trigMain | output | 1 | Main trigger output |
| trigAux | output | 1 | Auxiliary trigger output |

## Verification
Two functions can land in the same cycle: a selected rising edge on one reference together with a selected falling edge on another, and the software update strobe together with a counter reset. The bench provokes both by driving the two sources in the same cycle. It judges the result by checking that the output is high for exactly the cycle after the edge and low in the cycle that follows, so coalesced events give one pulse and never two.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
  localparam int MAIN_LSB = 4;
  localparam int MAIN_W   = 3;
  localparam int AUX_LSB  = 20;
  localparam int AUX_W    = 4;
  localparam int REF_N    = 6;

  // strobes and levels handed from control to datapath
  typedef struct packed {
    logic rstPulse;
    logic enLevel;
    logic updPulse;
    logic cmpPulse;
  } evt_t;
endpackage

// File: rtl/trig_sel_ctrl.sv
module trig_sel_ctrl
  import trig_sel_pkg::*;
#(
  parameter bit HAS_AUX = 1'b1,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              swUpdate,
  input  logic              cntReset,
  input  logic              cntEnable,
  input  logic              cntUpdate,
  input  logic              cmpMatch,
  output logic [MAIN_W-1:0] mainMode,
  output logic [AUX_W-1:0]  auxMode,
  output evt_t              evt
);
  localparam int MAIN_MSB = MAIN_LSB + MAIN_W - 1;
  localparam int AUX_MSB  = AUX_LSB + AUX_W - 1;

  logic [MAIN_W-1:0] mainQ;

  always_ff @(posedge clk) begin
    if (rst)        mainQ <= '0;
    else if (regWe) mainQ <= regWdata[MAIN_MSB:MAIN_LSB];
  end

  generate
    if (HAS_AUX) begin : g_aux
      logic [AUX_W-1:0] auxQ;
      always_ff @(posedge clk) begin
        if (rst)        auxQ <= '0;
        else if (regWe) auxQ <= regWdata[AUX_MSB:AUX_LSB];
      end
      assign auxMode = auxQ;
    end else begin : g_noaux
      assign auxMode = '0;
    end
  endgenerate

  assign mainMode = mainQ;

  always_comb begin
    regRdata = '0;
    regRdata[MAIN_MSB:MAIN_LSB] = mainQ;
    regRdata[AUX_MSB:AUX_LSB]   = auxMode;
  end

  // software update acts both as an update and as a reset event
  always_comb begin
    evt.rstPulse = cntReset | swUpdate;
    evt.enLevel  = cntEnable;
    evt.updPulse = cntUpdate | swUpdate;
    evt.cmpPulse = cmpMatch;
  end

  p_main_store_r2: assert property (@(posedge clk) disable iff (rst)
    regWe |=> regRdata[MAIN_MSB:MAIN_LSB] == $past(regWdata[MAIN_MSB:MAIN_LSB]));

  p_reset_fields_r1: assert property (@(posedge clk)
    rst |=> (mainMode == '0 && auxMode == '0));
endmodule

// File: rtl/trig_sel_path.sv
module trig_sel_path
  import trig_sel_pkg::*;
#(
  parameter bit HAS_AUX = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAIN_W-1:0] mainMode,
  input  logic [AUX_W-1:0]  auxMode,
  input  evt_t              evt,
  input  logic [REF_N-1:0]  ocRef,
  output logic              trigMain,
  output logic              trigAux
);
  logic [REF_N-1:0] ocRefQ;
  logic [REF_N-1:0] riseEdge;
  logic [REF_N-1:0] fallEdge;
  logic             mainNext;
  logic             trigMainQ;

  function automatic logic pickBase(input logic [2:0] code, input evt_t e,
                                    input logic [REF_N-1:0] r);
    case (code)
      3'd0:    pickBase = e.rstPulse;
      3'd1:    pickBase = e.enLevel;
      3'd2:    pickBase = e.updPulse;
      3'd3:    pickBase = e.cmpPulse;
      default: pickBase = r[code[1:0]];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) ocRefQ <= '0;
    else     ocRefQ <= ocRef;
  end

  assign riseEdge = ocRef & ~ocRefQ;
  assign fallEdge = ~ocRef & ocRefQ;
  assign mainNext = pickBase(mainMode, evt, ocRef);

  always_ff @(posedge clk) begin
    if (rst) trigMainQ <= 1'b0;
    else     trigMainQ <= mainNext;
  end
  assign trigMain = trigMainQ;

  generate
    if (HAS_AUX) begin : g_aux
      logic auxNext;
      logic trigAuxQ;
      always_comb begin
        case (auxMode)
          4'd8:    auxNext = ocRef[4];
          4'd9:    auxNext = ocRef[5];
          4'd10:   auxNext = riseEdge[3] | fallEdge[3];
          4'd11:   auxNext = riseEdge[5] | fallEdge[5];
          4'd12:   auxNext = riseEdge[3] | riseEdge[5];
          4'd13:   auxNext = riseEdge[3] | fallEdge[5];
          4'd14:   auxNext = riseEdge[4] | riseEdge[5];
          4'd15:   auxNext = riseEdge[4] | fallEdge[5];
          default: auxNext = pickBase(auxMode[2:0], evt, ocRef);
        endcase
      end
      always_ff @(posedge clk) begin
        if (rst) trigAuxQ <= 1'b0;
        else     trigAuxQ <= auxNext;
      end
      assign trigAux = trigAuxQ;

      p_edge_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (auxMode == 4'd10 && ocRef[3] == ocRefQ[3]) |=> !trigAux);
    end else begin : g_noaux
      assign trigAux = 1'b0;
    end
  endgenerate

  p_out_reset_r1: assert property (@(posedge clk)
    rst |=> (!trigMain && !trigAux));

  p_main_level_r3: assert property (@(posedge clk) disable iff (rst)
    (mainMode == 3'd4) |=> trigMain == $past(ocRef[0]));
endmodule

// File: rtl/trig_out_select.sv
module trig_out_select
  import trig_sel_pkg::*;
#(
  parameter bit HAS_AUX = 1'b1,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              swUpdate,
  input  logic              cntReset,
  input  logic              cntEnable,
  input  logic              cntUpdate,
  input  logic              cmpMatch,
  input  logic [REF_N-1:0]  ocRef,
  output logic              trigMain,
  output logic              trigAux
);
  logic [MAIN_W-1:0] mainMode;
  logic [AUX_W-1:0]  auxMode;
  evt_t              evt;

  trig_sel_ctrl #(.HAS_AUX(HAS_AUX), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .swUpdate(swUpdate), .cntReset(cntReset),
    .cntEnable(cntEnable), .cntUpdate(cntUpdate), .cmpMatch(cmpMatch),
    .mainMode(mainMode), .auxMode(auxMode), .evt(evt)
  );

  trig_sel_path #(.HAS_AUX(HAS_AUX)) path_i (
    .clk(clk), .rst(rst), .mainMode(mainMode), .auxMode(auxMode),
    .evt(evt), .ocRef(ocRef), .trigMain(trigMain), .trigAux(trigAux)
  );

  p_swupd_main_r8: assert property (@(posedge clk) disable iff (rst)
    (mainMode == 3'd2 && swUpdate) |=> trigMain);
endmodule

// File: tb/trig_out_select_tb_top.sv
module trig_out_select_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        regWe;
  logic [31:0] regWdata;
  logic [31:0] regRdata, regRdataNa;
  logic        swUpdate, cntReset, cntEnable, cntUpdate, cmpMatch;
  logic [5:0]  ocRef;
  logic        trigMain, trigAux, trigMainNa, trigAuxNa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_out_select dut_i (
    .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .swUpdate(swUpdate), .cntReset(cntReset),
    .cntEnable(cntEnable), .cntUpdate(cntUpdate), .cmpMatch(cmpMatch),
    .ocRef(ocRef), .trigMain(trigMain), .trigAux(trigAux)
  );

  trig_out_select #(.HAS_AUX(1'b0)) dutNoAux_i (
    .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdataNa), .swUpdate(swUpdate), .cntReset(cntReset),
    .cntEnable(cntEnable), .cntUpdate(cntUpdate), .cmpMatch(cmpMatch),
    .ocRef(ocRef), .trigMain(trigMainNa), .trigAux(trigAuxNa)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    swUpdate = 0; cntReset = 0; cntEnable = 0; cntUpdate = 0; cmpMatch = 0;
    ocRef = '0;
  endtask

  task automatic writeCtl(input logic [31:0] d);
    regWe = 1; regWdata = d;
    step();
    regWe = 0;
  endtask

  // drive only the source named by a base code 0..7 (or 8/9 for aux)
  task automatic driveSrc(input int code, input logic v);
    case (code)
      0: cntReset = v;
      1: cntEnable = v;
      2: cntUpdate = v;
      3: cmpMatch = v;
      8: ocRef[4] = v;
      9: ocRef[5] = v;
      default: ocRef[code-4] = v;
    endcase
  endtask

  task automatic t_reset();
    check("R1 read", regRdata, 32'h0);
    check("R1 main", {31'b0, trigMain}, 32'h0);
    check("R1 aux", {31'b0, trigAux}, 32'h0);
  endtask

  task automatic t_readback();
    writeCtl(32'hFFFF_FFFF);
    check("R2 readback", regRdata, 32'h00F0_0070);
    check("R9 noaux readback", regRdataNa, 32'h0000_0070);
    writeCtl(32'h0050_0030);
    check("R2 fields", regRdata, 32'h0050_0030);
    writeCtl(32'h0);
  endtask

  task automatic t_main();
    for (int c = 0; c < 8; c++) begin
      writeCtl(32'(c) << 4);
      driveSrc(c, 1'b1);
      step();
      check($sformatf("R3 main code %0d high", c), {31'b0, trigMain}, 32'h1);
      clearIn();
      step();
      check($sformatf("R3 main code %0d low", c), {31'b0, trigMain}, 32'h0);
    end
    writeCtl(32'h0);
    step();
  endtask

  task automatic t_aux_levels();
    for (int c = 0; c < 10; c++) begin
      writeCtl(32'(c) << 20);
      driveSrc(c, 1'b1);
      step();
      check($sformatf("R4 aux code %0d high", c), {31'b0, trigAux}, 32'h1);
      clearIn();
      step();
      check($sformatf("R4 aux code %0d low", c), {31'b0, trigAux}, 32'h0);
    end
    writeCtl(32'h0);
    step();
  endtask

  task automatic t_both_edges(input int code, input int bitIdx);
    writeCtl(32'(code) << 20);
    ocRef[bitIdx] = 1; step();
    check($sformatf("R5 code %0d rise", code), {31'b0, trigAux}, 32'h1);
    step();
    check($sformatf("R5 code %0d width", code), {31'b0, trigAux}, 32'h0);
    ocRef[bitIdx] = 0; step();
    check($sformatf("R5 code %0d fall", code), {31'b0, trigAux}, 32'h1);
    step();
    check($sformatf("R5 code %0d end", code), {31'b0, trigAux}, 32'h0);
  endtask

  task automatic t_combo(input int code, input int aIdx, input bit bFall);
    writeCtl(32'(code) << 20);
    ocRef[aIdx] = 1; step();
    check($sformatf("R6 code %0d A rise", code), {31'b0, trigAux}, 32'h1);
    step();
    check($sformatf("R6 code %0d A width", code), {31'b0, trigAux}, 32'h0);
    ocRef[aIdx] = 0; step();
    check($sformatf("R6 code %0d A fall ignored", code), {31'b0, trigAux}, 32'h0);
    ocRef[5] = 1; step();
    check($sformatf("R6 code %0d B rise", code), {31'b0, trigAux}, bFall ? 32'h0 : 32'h1);
    ocRef[5] = 0; step();
    check($sformatf("R6 code %0d B fall", code), {31'b0, trigAux}, bFall ? 32'h1 : 32'h0);
    step();
    check($sformatf("R6 code %0d idle", code), {31'b0, trigAux}, 32'h0);
  endtask

  task automatic t_same_cycle();
    writeCtl(32'h00D0_0000);
    ocRef[5] = 1; step(); step();
    ocRef[3] = 1; ocRef[5] = 0; step();
    check("R7 coincident edges pulse", {31'b0, trigAux}, 32'h1);
    step();
    check("R7 coincident edges single", {31'b0, trigAux}, 32'h0);
    clearIn(); step();
    writeCtl(32'h0);
    step();
  endtask

  task automatic t_swupdate();
    writeCtl(32'h0000_0020);
    swUpdate = 1; step(); swUpdate = 0;
    check("R8 update mode sw pulse", {31'b0, trigMain}, 32'h1);
    step();
    check("R8 update mode end", {31'b0, trigMain}, 32'h0);
    writeCtl(32'h0);
    swUpdate = 1; cntReset = 1; step(); swUpdate = 0; cntReset = 0;
    check("R8 reset mode coincident", {31'b0, trigMain}, 32'h1);
    step();
    check("R8 reset mode single", {31'b0, trigMain}, 32'h0);
  endtask

  task automatic t_noaux();
    writeCtl(32'h00A0_0000);
    check("R9 noaux write ignored", regRdataNa, 32'h0);
    ocRef[3] = 1; step();
    check("R9 noaux aux low", {31'b0, trigAuxNa}, 32'h0);
    ocRef[3] = 0; step();
    check("R9 noaux aux low fall", {31'b0, trigAuxNa}, 32'h0);
    writeCtl(32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1; regWe = 0; regWdata = '0;
    clearIn();
    step(); step(); step();
    check("R1 during reset main", {31'b0, trigMain}, 32'h0);
    rst = 0;
    step();
    t_reset();
    t_readback();
    t_main();
    t_aux_levels();
    t_both_edges(10, 3);
    t_both_edges(11, 5);
    t_combo(12, 3, 1'b0);
    t_combo(13, 3, 1'b1);
    t_combo(14, 4, 1'b0);
    t_combo(15, 4, 1'b1);
    t_same_cycle();
    t_swupdate();
    t_noaux();
    finishRun();
  end
endmodule